// File: doc/BRIEF.md
# Translation Cache with Victim Buffer

This block turns a linear page number into a physical page number and a set of permission bits. It has three stores. The first is a direct-mapped main array. The second is a small fully associative victim buffer, which catches entries that a refill pushes out of the main array. The third is a small fully associative cache of directory tags, so that a page walker can skip the directory read when the directory part of a missing address has been seen recently.

The lookup port is combinational. In the cycle an address is presented, the block returns whether it hit, the physical page, the permission bits, whether the directory tag is cached, and a flag saying that only the page-table read is needed. When a lookup hits in the victim buffer, the entry trades places with whatever occupies its main-array slot at the next clock edge. A refill port installs a translation after a walk, and a directory-fill port records a directory tag. A flush input empties every store in one cycle.

Top module: `tlb_xlate_cache`

## Requirements
- R1: After reset, and in any cycle with `lk_valid` low, `lk_hit`, `lk_dir_hit` and `lk_walk_short` are 0.
- R2: The main array has 128 slots. A slot is picked by `lpn[6:0]`, and `lpn[19:7]` is kept as its tag. After a refill of (lpn, ppn, perm), a lookup of that lpn in the next cycle hits in the same cycle it is presented and returns that ppn and perm.
- R3: A refill whose slot holds a valid entry with a different tag moves the old entry into the victim buffer, so a later lookup of the old lpn still hits with its old ppn and perm. A refill of the same tag overwrites the entry in place and moves nothing.
- R4: The victim buffer holds 8 entries. Entries enter at a pointer that starts at slot 0 after reset or flush and advances by one per insertion, wrapping after slot 7. When the buffer is full, the oldest inserted entry is therefore overwritten and its lpn misses.
- R5: A lookup that hits in the victim buffer returns the correct ppn and perm in that same cycle. At the next edge, the entry moves into its main slot and the former main entry of that slot takes its victim slot. If that main slot was empty, the victim slot is left empty.
- R6: An lpn is never present in both the main array and the victim buffer. A refill of an lpn held in the victim buffer removes the victim copy.
- R7: The directory cache holds 4 tags, each tag being `lpn[19:10]`. A fill whose tag is absent is written at a pointer that replaces the oldest fill first. A fill whose tag is present changes nothing. `lk_dir_hit` is 1 when the lookup's directory tag is cached.
- R8: `lk_walk_short` is 1 exactly when a valid lookup misses both page stores but its directory tag is cached.
- R9: `flush` empties all three stores at the next edge and resets both pointers. It takes priority over a refill, a directory fill and a swap in the same cycle.
- R10: When a refill and a victim-hit lookup occur in the same cycle, the refill is applied and the swap is not performed. The lookup still returns its translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all stores |
| lk_valid | input | 1 | Lookup request |
| lk_lpn | input | 20 | Lookup linear page number |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | 20 | Physical page number (valid on hit) |
| lk_perm | output | 3 | Permission bits (valid on hit) |
| lk_dir_hit | output | 1 | Directory tag of lookup is cached |
| lk_walk_short | output | 1 | Miss that needs only the page-table read |
| rf_valid | input | 1 | Install a translation |
| rf_lpn | input | 20 | Refill linear page number |
| rf_ppn | input | 20 | Refill physical page number |
| rf_perm | input | 3 | Refill permission bits |
| df_valid | input | 1 | Record a directory tag |
| df_lpn | input | 20 | Address whose bits 19:10 form the directory tag |

## Verification
The case that is hardest to reach from the ports is a victim buffer that has wrapped while its slots have been reshuffled by swaps. In that state the order in which entries are lost depends on the whole history of refills, swaps and same-cycle conflicts. The stimulus reaches it by drawing addresses from only four main slots and forty tags, so refills keep evicting entries. Random lookups mostly hit those same addresses, which makes swaps frequent, and refills are randomly placed in the same cycle as victim hits. Directed sequences add a wrap with ten tags on one slot, a refill of an address held in the victim buffer, a flush issued together with a refill, and a directory-cache overflow.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int LPN_W      = 20;
  localparam int PPN_W      = 20;
  localparam int PERM_W     = 3;
  localparam int MAIN_IDX_W = 7;
  localparam int DIR_SHIFT  = 10;
  localparam int MAIN_TAG_W = LPN_W - MAIN_IDX_W;
  localparam int MAIN_N     = 1 << MAIN_IDX_W;
  localparam int DIR_TAG_W  = LPN_W - DIR_SHIFT;

  typedef logic [LPN_W-1:0]      lpn_t;
  typedef logic [PPN_W-1:0]      ppn_t;
  typedef logic [PERM_W-1:0]     perm_t;
  typedef logic [MAIN_IDX_W-1:0] midx_t;
  typedef logic [MAIN_TAG_W-1:0] mtag_t;
  typedef logic [DIR_TAG_W-1:0]  dtag_t;

  typedef struct packed {
    logic  v;
    mtag_t tag;
    ppn_t  ppn;
    perm_t perm;
  } main_ent_t;

  typedef struct packed {
    logic  v;
    lpn_t  lpn;
    ppn_t  ppn;
    perm_t perm;
  } vic_ent_t;

  function automatic midx_t slot_of(lpn_t lpn);
    return lpn[MAIN_IDX_W-1:0];
  endfunction

  function automatic mtag_t tag_of(lpn_t lpn);
    return lpn[LPN_W-1:MAIN_IDX_W];
  endfunction

  function automatic dtag_t dir_of(lpn_t lpn);
    return lpn[LPN_W-1:DIR_SHIFT];
  endfunction

  function automatic lpn_t rebuild_lpn(mtag_t tag, midx_t idx);
    return {tag, idx};
  endfunction
endpackage

// File: rtl/tlbx_main_array.sv
module tlbx_main_array
  import tlbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  midx_t     ra_idx,
  output main_ent_t ra_ent,
  input  midx_t     rb_idx,
  output main_ent_t rb_ent,
  input  logic      we,
  input  midx_t     widx,
  input  main_ent_t wdata
);
  main_ent_t ent_q [MAIN_N];

  assign ra_ent = ent_q[ra_idx];
  assign rb_ent = ent_q[rb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < MAIN_N; i++) ent_q[i].v <= 1'b0;
    end else if (we) begin
      ent_q[widx] <= wdata;
    end
  end
endmodule

// File: rtl/tlbx_victim_buf.sv
module tlbx_victim_buf
  import tlbx_pkg::*;
#(
  parameter int VIC_N = 8,
  localparam int VIC_W = (VIC_N > 1) ? $clog2(VIC_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  lpn_t             look_lpn,
  output logic             look_match,
  output logic [VIC_W-1:0] look_slot,
  output vic_ent_t         look_ent,
  input  logic             kill_en,
  input  lpn_t             kill_lpn,
  input  logic             swap_en,
  input  logic [VIC_W-1:0] swap_slot,
  input  vic_ent_t         swap_data,
  input  logic             push_en,
  input  vic_ent_t         push_data
);
  vic_ent_t         ent_q [VIC_N];
  logic [VIC_W-1:0] ptr_q;

  always_comb begin
    look_match = 1'b0;
    look_slot  = '0;
    for (int i = 0; i < VIC_N; i++) begin
      if (ent_q[i].v && ent_q[i].lpn == look_lpn) begin
        look_match = 1'b1;
        look_slot  = VIC_W'(i);
      end
    end
    look_ent = ent_q[look_slot];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < VIC_N; i++) ent_q[i].v <= 1'b0;
      ptr_q <= '0;
    end else begin
      if (kill_en) begin
        for (int i = 0; i < VIC_N; i++)
          if (ent_q[i].v && ent_q[i].lpn == kill_lpn) ent_q[i].v <= 1'b0;
      end
      if (swap_en) ent_q[swap_slot] <= swap_data;
      if (push_en) begin
        ent_q[ptr_q] <= push_data;
        ptr_q <= (ptr_q == VIC_W'(VIC_N-1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlbx_dir_cache.sv
module tlbx_dir_cache
  import tlbx_pkg::*;
#(
  parameter int DIR_N = 4,
  localparam int DP_W = (DIR_N > 1) ? $clog2(DIR_N) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  lpn_t look_lpn,
  output logic look_match,
  input  logic fill_en,
  input  lpn_t fill_lpn
);
  logic [DIR_N-1:0] v_q;
  dtag_t            tag_q [DIR_N];
  logic [DP_W-1:0]  ptr_q;
  logic             fill_present;

  always_comb begin
    look_match   = 1'b0;
    fill_present = 1'b0;
    for (int i = 0; i < DIR_N; i++) begin
      if (v_q[i] && tag_q[i] == dir_of(look_lpn)) look_match   = 1'b1;
      if (v_q[i] && tag_q[i] == dir_of(fill_lpn)) fill_present = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      v_q   <= '0;
      ptr_q <= '0;
    end else if (fill_en && !fill_present) begin
      v_q[ptr_q]   <= 1'b1;
      tag_q[ptr_q] <= dir_of(fill_lpn);
      ptr_q <= (ptr_q == DP_W'(DIR_N-1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate_cache.sv
module tlb_xlate_cache
  import tlbx_pkg::*;
#(
  parameter int VIC_N = 8,
  parameter int DIR_N = 4,
  localparam int VIC_W = (VIC_N > 1) ? $clog2(VIC_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [LPN_W-1:0]  lk_lpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  output logic              lk_dir_hit,
  output logic              lk_walk_short,
  input  logic              rf_valid,
  input  logic [LPN_W-1:0]  rf_lpn,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [PERM_W-1:0] rf_perm,
  input  logic              df_valid,
  input  logic [LPN_W-1:0]  df_lpn
);
  main_ent_t        look_main, fill_main, main_wdata;
  logic             main_we;
  midx_t            main_widx;
  logic             vic_match, dir_match;
  logic [VIC_W-1:0] vic_slot;
  vic_ent_t         vic_ent, vic_swap_data, vic_push_data;

  // named internal events, observed by the checker
  logic main_hit, vic_hit, swap_fire, refill_go, evict_go;

  tlbx_main_array u_main (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ra_idx(slot_of(lk_lpn)), .ra_ent(look_main),
    .rb_idx(slot_of(rf_lpn)), .rb_ent(fill_main),
    .we(main_we), .widx(main_widx), .wdata(main_wdata)
  );

  tlbx_victim_buf #(.VIC_N(VIC_N)) u_vic (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .look_lpn(lk_lpn), .look_match(vic_match), .look_slot(vic_slot), .look_ent(vic_ent),
    .kill_en(refill_go), .kill_lpn(rf_lpn),
    .swap_en(swap_fire), .swap_slot(vic_slot), .swap_data(vic_swap_data),
    .push_en(evict_go), .push_data(vic_push_data)
  );

  tlbx_dir_cache #(.DIR_N(DIR_N)) u_dir (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .look_lpn(lk_lpn), .look_match(dir_match),
    .fill_en(df_valid), .fill_lpn(df_lpn)
  );

  always_comb begin
    main_hit  = lk_valid && look_main.v && (look_main.tag == tag_of(lk_lpn));
    vic_hit   = lk_valid && vic_match;
    refill_go = rf_valid && !flush;
    swap_fire = vic_hit && !rf_valid && !flush;
    evict_go  = refill_go && fill_main.v && (fill_main.tag != tag_of(rf_lpn));

    lk_hit        = main_hit || vic_hit;
    lk_ppn        = main_hit ? look_main.ppn  : vic_ent.ppn;
    lk_perm       = main_hit ? look_main.perm : vic_ent.perm;
    lk_dir_hit    = lk_valid && dir_match;
    lk_walk_short = lk_valid && !lk_hit && dir_match;

    vic_swap_data = '{v: look_main.v, lpn: rebuild_lpn(look_main.tag, slot_of(lk_lpn)),
                      ppn: look_main.ppn, perm: look_main.perm};
    vic_push_data = '{v: 1'b1, lpn: rebuild_lpn(fill_main.tag, slot_of(rf_lpn)),
                      ppn: fill_main.ppn, perm: fill_main.perm};

    main_we = refill_go || swap_fire;
    if (rf_valid) begin
      main_widx  = slot_of(rf_lpn);
      main_wdata = '{v: 1'b1, tag: tag_of(rf_lpn), ppn: rf_ppn, perm: rf_perm};
    end else begin
      main_widx  = slot_of(lk_lpn);
      main_wdata = '{v: 1'b1, tag: tag_of(vic_ent.lpn), ppn: vic_ent.ppn, perm: vic_ent.perm};
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlbx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        lk_valid,
  input lpn_t        lk_lpn,
  input logic        lk_hit,
  input ppn_t        lk_ppn,
  input logic        lk_dir_hit,
  input logic        lk_walk_short,
  input logic        rf_valid,
  input lpn_t        rf_lpn,
  input ppn_t        rf_ppn,
  input logic        main_hit,
  input logic        vic_hit,
  input logic        swap_fire
);
  assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_dir_hit && !lk_walk_short));

  assert_refill_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !flush) |=>
      (!(lk_valid && lk_lpn == $past(rf_lpn)) || (lk_hit && lk_ppn == $past(rf_ppn))));

  assert_swap_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> (!(lk_valid && lk_lpn == $past(lk_lpn)) || main_hit));

  assert_single_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_hit && vic_hit));

  assert_short_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_walk_short |-> (!lk_hit && lk_dir_hit));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_hit && !lk_dir_hit));
endmodule

bind tlb_xlate_cache tlb_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .lk_valid(lk_valid), .lk_lpn(lk_lpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
  .lk_dir_hit(lk_dir_hit), .lk_walk_short(lk_walk_short),
  .rf_valid(rf_valid), .rf_lpn(rf_lpn), .rf_ppn(rf_ppn),
  .main_hit(main_hit), .vic_hit(vic_hit), .swap_fire(swap_fire)
);

// File: tb/test_tlb_xlate_cache.sv
module test_tlb_xlate_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 128, NV = 8, ND = 4;

  logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic        lk_valid = 1'b0, rf_valid = 1'b0, df_valid = 1'b0;
  logic [19:0] lk_lpn = '0, rf_lpn = '0, rf_ppn = '0, df_lpn = '0;
  logic [2:0]  rf_perm = '0;
  logic        lk_hit, lk_dir_hit, lk_walk_short;
  logic [19:0] lk_ppn;
  logic [2:0]  lk_perm;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate_cache i_tlb_xlate_cache (.*);

  // reference stores
  bit          m_v [NM];
  logic [12:0] m_tag [NM];
  logic [19:0] m_ppn [NM];
  logic [2:0]  m_perm [NM];
  bit          v_v [NV];
  logic [19:0] v_lpn [NV], v_ppn [NV];
  logic [2:0]  v_perm [NV];
  int          v_ptr;
  bit          d_v [ND];
  logic [9:0]  d_tag [ND];
  int          d_ptr;

  task automatic model_clear();
    for (int i = 0; i < NM; i++) m_v[i] = 0;
    for (int i = 0; i < NV; i++) v_v[i] = 0;
    for (int i = 0; i < ND; i++) d_v[i] = 0;
    v_ptr = 0; d_ptr = 0;
  endtask

  function automatic int vic_find(logic [19:0] lpn);
    for (int i = 0; i < NV; i++) if (v_v[i] && v_lpn[i] == lpn) return i;
    return -1;
  endfunction

  function automatic bit dir_find(logic [19:0] lpn);
    for (int i = 0; i < ND; i++) if (d_v[i] && d_tag[i] == lpn[19:10]) return 1;
    return 0;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit lv, logic [19:0] ll, bit rv, logic [19:0] rl, logic [19:0] rp,
                     logic [2:0] rperm, bit dv, logic [19:0] dl, bit fl, string req);
    int   mi, vj;
    bit   mh, vh, eh, ed;
    logic [19:0] ep;
    logic [2:0]  eperm;
    @(negedge clk);
    lk_valid = lv; lk_lpn = ll; rf_valid = rv; rf_lpn = rl; rf_ppn = rp; rf_perm = rperm;
    df_valid = dv; df_lpn = dl; flush = fl;
    #1;
    mi = int'(ll[6:0]);
    mh = lv && m_v[mi] && m_tag[mi] == ll[19:7];
    vj = vic_find(ll);
    vh = lv && (vj >= 0) && !mh;
    eh = mh || vh;
    ep = mh ? m_ppn[mi] : (vh ? v_ppn[vj] : 20'h0);
    eperm = mh ? m_perm[mi] : (vh ? v_perm[vj] : 3'h0);
    ed = lv && dir_find(ll);
    check(lk_hit == eh, lv ? req : "R1", "hit", 32'(lk_hit), 32'(eh));
    if (eh) begin
      check(lk_ppn == ep, vh ? "R5" : req, "ppn", 32'(lk_ppn), 32'(ep));
      check(lk_perm == eperm, vh ? "R5" : req, "perm", 32'(lk_perm), 32'(eperm));
    end
    check(lk_dir_hit == ed, "R7", "dir_hit", 32'(lk_dir_hit), 32'(ed));
    check(lk_walk_short == (lv && !eh && ed), "R8", "walk_short", 32'(lk_walk_short),
          32'(lv && !eh && ed));
    @(posedge clk);
    if (fl) begin
      model_clear();
    end else begin
      if (rv) begin
        int ri = int'(rl[6:0]);
        for (int i = 0; i < NV; i++) if (v_v[i] && v_lpn[i] == rl) v_v[i] = 0;
        if (m_v[ri] && m_tag[ri] != rl[19:7]) begin
          v_v[v_ptr] = 1; v_lpn[v_ptr] = {m_tag[ri], rl[6:0]};
          v_ppn[v_ptr] = m_ppn[ri]; v_perm[v_ptr] = m_perm[ri];
          v_ptr = (v_ptr + 1) % NV;
        end
        m_v[ri] = 1; m_tag[ri] = rl[19:7]; m_ppn[ri] = rp; m_perm[ri] = rperm;
      end else if (vh) begin
        bit          tv = m_v[mi];
        logic [12:0] tt = m_tag[mi];
        logic [19:0] tp = m_ppn[mi];
        logic [2:0]  tq = m_perm[mi];
        m_v[mi] = 1; m_tag[mi] = ll[19:7]; m_ppn[mi] = v_ppn[vj]; m_perm[mi] = v_perm[vj];
        v_v[vj] = tv; v_lpn[vj] = {tt, ll[6:0]}; v_ppn[vj] = tp; v_perm[vj] = tq;
      end
      if (dv && !dir_find(dl)) begin
        d_v[d_ptr] = 1; d_tag[d_ptr] = dl[19:10];
        d_ptr = (d_ptr + 1) % ND;
      end
    end
  endtask

  function automatic logic [19:0] pick_lpn();
    return (20'($urandom_range(0, 39)) << 7) | 20'($urandom_range(0, 3));
  endfunction

  task automatic lookup(logic [19:0] l, string req);
    cyc(1, l, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic refill(logic [19:0] l, logic [19:0] p, logic [2:0] q, string req);
    cyc(0, 0, 1, l, p, q, 0, 0, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    lookup(20'h00283, "R1");
    cyc(0, 20'h00283, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2: install and read back
    refill(20'h00283, 20'h12345, 3'd5, "R2");
    lookup(20'h00283, "R2");
    // R3: displaced entry lands in the victim buffer; R5: victim hit and swap
    refill(20'h00483, 20'h0abcd, 3'd2, "R3");
    lookup(20'h00283, "R3");
    lookup(20'h00483, "R5");
    lookup(20'h00283, "R5");
    // R3: same-tag refill overwrites in place
    refill(20'h00283, 20'h55555, 3'd7, "R3");
    lookup(20'h00283, "R3");
    // R6: refill of an lpn held in the victim buffer
    refill(20'h00483, 20'h77777, 3'd1, "R6");
    lookup(20'h00483, "R6");
    lookup(20'h00283, "R6");
    // R9: flush together with a refill
    cyc(0, 0, 1, 20'h00101, 20'h11111, 3'd3, 1, 20'h00101, 1, "R9");
    lookup(20'h00101, "R9");
    lookup(20'h00283, "R9");
    // R4: ten tags on one slot wrap the victim buffer
    for (int t = 0; t < 10; t++) refill(20'((t << 7) | 1), 20'(t + 16), 3'(t), "R4");
    lookup(20'h00001, "R4");
    lookup(20'h00081, "R4");
    // R10: refill and victim hit in one cycle
    cyc(1, 20'h00101, 1, 20'h00002, 20'h0beef, 3'd4, 0, 0, 0, "R10");
    for (int t = 1; t < 10; t++) lookup(20'((t << 7) | 1), "R10");
    // R7: directory cache overflow
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    for (int t = 0; t < 5; t++) cyc(0, 0, 0, 0, 0, 0, 1, 20'(t << 10), 0, "R7");
    lookup(20'h00000, "R7");
    lookup(20'h01005, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, 20'h01000, 0, "R7");
    lookup(20'h00c00, "R7");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit rv = ($urandom_range(0, 3) == 0);
      bit dv = ($urandom_range(0, 4) == 0);
      bit fl = ($urandom_range(0, 499) == 0);
      cyc($urandom_range(0, 5) != 0, pick_lpn(), rv, pick_lpn(), 20'($urandom),
          3'($urandom), dv, pick_lpn(), fl, "R5");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule